// File: doc/BRIEF.md
# Prefixed Add-Immediate Decode Unit

This unit takes a stream of 32-bit instruction words, each with its address, and turns the add-immediate family into finished sums. It handles three shapes. The first is a single-word add-immediate. The second is a two-word form: a wide prefix carries the upper part of a 34-bit immediate and a PC-relative flag, and a suffix follows it. The third is a two-word vector form: its prefix carries extension bits that widen both register numbers from 5 to 7 bits. Only element 0 of the vector form is computed. The suffix always keeps the single-word field layout, and its opcode must still be add-immediate.

The source operand comes from a register-file read port that this unit drives. The port is read combinationally in the cycle the final word is accepted. The result and its 7-bit destination register are presented on a valid/ready output. The input is valid/ready as well: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While a result sits unconsumed, no word is accepted. A result is held stable until `res_ready` takes it. The illegal-suffix flag is a plain one-cycle pulse and is not subject to back-pressure.

Top module: `iad_decoder`

## Requirements
- R1: A word whose opcode (bits 31:26, MSB-0 bits 0-5) is 14, accepted with no prefix held, produces a result one cycle later. The result is base + sign-extended SI (bits 15:0). The destination is RT (bits 25:21). The register-file address is RA (bits 20:16).
- R2: Whenever the source register number is 0, the base is a literal zero and not register 0. This applies to the single-word form, to the wide form with the flag clear, and to the vector form when the 7-bit extended number is 0.
- R3: A wide prefix is held only if it has opcode 1, bits 25:24 equal to 2 and bit 23 clear. Any other word with no prefix held whose opcode is not 14 or 9 produces no result and no flag.
- R4: The wide form's immediate is prefix bits 17:0 placed above suffix bits 15:0, and this 34-bit value is sign-extended.
- R5: When prefix bit 20 is set, the wide form's base is the address of the prefix word, not a register.
- R6: A vector prefix has opcode 9 and EXTRA in bits 14:5 (MSB-0 17-26, EXTRA bit k at MSB-0 bit 17+k). The source number is {RA, EXTRA bit 1, EXTRA bit 2} and the destination is {RT, EXTRA bit 4, EXTRA bit 5}. EXTRA bits 0 and 3 are ignored. The immediate is SI sign-extended.
- R7: If the word after a held prefix does not have opcode 14, `illegal` pulses for exactly one cycle, the next cycle. No result is produced and the prefix is dropped.
- R8: While `res_valid` is high and `res_ready` is low, the result and destination stay stable and `in_ready` is low.
- R9: Reset clears any held prefix, `res_valid` and `illegal`, and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word accepted this cycle when high together with in_valid |
| in_word | input | 32 | Instruction word |
| in_addr | input | XLEN | Address of the offered word |
| rf_addr | output | REG_W | Register-file read index (source register) |
| rf_data | input | XLEN | Register-file read data for rf_addr, same cycle |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | XLEN | Sum |
| res_dest | output | REG_W | Destination register number |
| illegal | output | 1 | One-cycle pulse: bad suffix after a prefix |

## Verification
The bench builds the unit with its default values: XLEN of 64 and REG_W of 7. With these values the 34-bit immediate's sign bit has to spread across the upper 30 bits. A PC-relative base with high address bits set wraps through the full 64-bit adder. Every register number up to 127 can be reached through the two extension bits. Random back-pressure on `res_ready` exercises the stall path under back-to-back pairs.

// File: rtl/iad_pkg.sv
package iad_pkg;

  localparam int WORD_W = 32;
  localparam int LO_W   = 16;
  localparam int HI_W   = 18;
  localparam int IMM_W  = HI_W + LO_W;

  localparam logic [5:0] OPC_ADDI = 6'd14;
  localparam logic [5:0] OPC_WIDE = 6'd1;
  localparam logic [5:0] OPC_VEC  = 6'd9;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_WIDE = 2'd1,
    PK_VEC  = 2'd2
  } pfx_kind_e;

  typedef struct packed {
    logic            is_add;
    logic            is_wide_pfx;
    logic            is_vec_pfx;
    logic [4:0]      rt;
    logic [4:0]      ra;
    logic [LO_W-1:0] lo_imm;
    logic            pc_rel;
    logic [HI_W-1:0] hi_imm;
    logic [1:0]      ra_ext;
    logic [1:0]      rt_ext;
  } insn_fields_t;

endpackage

// File: rtl/iad_classify.sv
module iad_classify
  import iad_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output insn_fields_t      f
);

  logic [5:0] opc;
  assign opc = word[31:26];

  always_comb begin
    f.is_add      = (opc == OPC_ADDI);
    // wide prefix: selector bits must read 2'b10 and the following bit 0
    f.is_wide_pfx = (opc == OPC_WIDE) && (word[25:24] == 2'b10) && !word[23];
    f.is_vec_pfx  = (opc == OPC_VEC);
    f.rt          = word[25:21];
    f.ra          = word[20:16];
    f.lo_imm      = word[15:0];
    f.pc_rel      = word[20];
    f.hi_imm      = word[17:0];
    // extension field sits in word[14:5]; slot k (MSB-0) is word[14-k]
    f.ra_ext      = {word[13], word[12]};
    f.rt_ext      = {word[10], word[9]};
  end

endmodule

// File: rtl/iad_regext.sv
module iad_regext #(
  parameter int FLD_W = 5,
  parameter int REG_W = 7
) (
  input  logic [FLD_W-1:0]       fld,
  input  logic [REG_W-FLD_W-1:0] ext,
  input  logic                   use_ext,
  output logic [REG_W-1:0]       num
);

  localparam int EXT_W = REG_W - FLD_W;

  assign num = use_ext ? {fld, ext} : {{EXT_W{1'b0}}, fld};

endmodule

// File: rtl/iad_sum.sv
module iad_sum #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 34
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rf_val,
  input  logic [XLEN-1:0]  pc,
  input  logic             zero_base,
  input  logic             pc_rel,
  output logic [XLEN-1:0]  sum
);

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] base;

  generate
    if (XLEN > IMM_W) begin : g_pad
      assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_x = imm[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    if (pc_rel)         base = pc;
    else if (zero_base) base = '0;
    else                base = rf_val;
  end

  assign sum = base + imm_x;

endmodule

// File: rtl/iad_decoder.sv
module iad_decoder
  import iad_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [XLEN-1:0]   in_addr,
  output logic [REG_W-1:0]  rf_addr,
  input  logic [XLEN-1:0]   rf_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [XLEN-1:0]   res_data,
  output logic [REG_W-1:0]  res_dest,
  output logic              illegal
);

  localparam int FLD_W = 5;
  localparam int EXT_W = REG_W - FLD_W;

  pfx_kind_e             held_q;
  logic [XLEN-1:0]       pfx_addr_q;
  logic                  pfx_pcrel_q;
  logic [HI_W-1:0]       pfx_hi_q;
  logic [EXT_W-1:0]      pfx_ra_ext_q;
  logic [EXT_W-1:0]      pfx_rt_ext_q;

  logic                  res_valid_q;
  logic [XLEN-1:0]       res_data_q;
  logic [REG_W-1:0]      res_dest_q;
  logic                  illegal_q;

  insn_fields_t          cur;
  logic                  fire;
  logic                  take_add;
  logic                  use_vec;
  logic                  use_wide;
  logic [REG_W-1:0]      ra_num;
  logic [REG_W-1:0]      rt_num;
  logic [IMM_W-1:0]      imm_full;
  logic [XLEN-1:0]       sum;

  iad_classify u_cls (
    .word (in_word),
    .f    (cur)
  );

  assign in_ready = ~res_valid_q | res_ready;
  assign fire     = in_valid & in_ready;
  assign take_add = fire & cur.is_add;
  assign use_vec  = (held_q == PK_VEC);
  assign use_wide = (held_q == PK_WIDE);

  iad_regext #(.FLD_W(FLD_W), .REG_W(REG_W)) u_ra_ext (
    .fld     (cur.ra),
    .ext     (pfx_ra_ext_q),
    .use_ext (use_vec),
    .num     (ra_num)
  );

  iad_regext #(.FLD_W(FLD_W), .REG_W(REG_W)) u_rt_ext (
    .fld     (cur.rt),
    .ext     (pfx_rt_ext_q),
    .use_ext (use_vec),
    .num     (rt_num)
  );

  assign rf_addr  = ra_num;
  assign imm_full = use_wide ? {pfx_hi_q, cur.lo_imm}
                             : {{HI_W{cur.lo_imm[LO_W-1]}}, cur.lo_imm};

  iad_sum #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sum (
    .imm       (imm_full),
    .rf_val    (rf_data),
    .pc        (pfx_addr_q),
    .zero_base (ra_num == '0),
    .pc_rel    (use_wide & pfx_pcrel_q),
    .sum       (sum)
  );

  // prefix holding state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q       <= PK_NONE;
      pfx_addr_q   <= '0;
      pfx_pcrel_q  <= 1'b0;
      pfx_hi_q     <= '0;
      pfx_ra_ext_q <= '0;
      pfx_rt_ext_q <= '0;
      illegal_q    <= 1'b0;
    end else begin
      illegal_q <= fire & (held_q != PK_NONE) & ~cur.is_add;
      if (fire) begin
        if (held_q != PK_NONE) begin
          held_q <= PK_NONE;
        end else if (cur.is_wide_pfx) begin
          held_q      <= PK_WIDE;
          pfx_addr_q  <= in_addr;
          pfx_pcrel_q <= cur.pc_rel;
          pfx_hi_q    <= cur.hi_imm;
        end else if (cur.is_vec_pfx) begin
          held_q       <= PK_VEC;
          pfx_ra_ext_q <= cur.ra_ext;
          pfx_rt_ext_q <= cur.rt_ext;
        end
      end
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
      res_dest_q  <= '0;
    end else if (take_add) begin
      res_valid_q <= 1'b1;
      res_data_q  <= sum;
      res_dest_q  <= rt_num;
    end else if (res_ready) begin
      res_valid_q <= 1'b0;
    end
  end

  assign res_valid = res_valid_q;
  assign res_data  = res_data_q;
  assign res_dest  = res_dest_q;
  assign illegal   = illegal_q;

endmodule

// File: rtl/iad_checker.sv
module iad_checker #(
  parameter int XLEN  = 64,
  parameter int REG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      in_word,
  input logic             res_valid,
  input logic             res_ready,
  input logic [XLEN-1:0]  res_data,
  input logic [REG_W-1:0] res_dest,
  input logic             illegal
);

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_dest)); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !in_ready); // R8

  AST_ILLEGAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal); // R7

  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(in_valid && in_ready && (in_word[31:26] != 6'd14))); // R7

  AST_ILLEGAL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !$rose(res_valid)); // R7

  AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid && in_ready && (in_word[31:26] == 6'd14))); // R1

endmodule

bind iad_decoder iad_checker #(.XLEN(XLEN), .REG_W(REG_W)) u_iad_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_dest  (res_dest),
  .illegal   (illegal)
);

// File: tb/tb_iad_decoder.sv
module tb_iad_decoder;

  localparam int XLEN  = 64;
  localparam int REG_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_word = '0;
  logic [XLEN-1:0]  in_addr = '0;
  logic [REG_W-1:0] rf_addr;
  logic [XLEN-1:0]  rf_data;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic [XLEN-1:0]  res_data;
  logic [REG_W-1:0] res_dest;
  logic             illegal;

  always #2 clk = ~clk;

  iad_decoder #(.XLEN(XLEN), .REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_addr(in_addr), .rf_addr(rf_addr), .rf_data(rf_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_dest(res_dest), .illegal(illegal)
  );

  function automatic logic [63:0] rfv(int idx);
    return 64'hC3A5_0000_0000_0000 ^ (64'(idx) * 64'h0001_0203_0405_0607) ^ 64'(idx);
  endfunction

  assign rf_data = rfv(int'(rf_addr));

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  bit    rdy_rand = 0;

  // reference model state
  int          m_kind = 0;
  logic [31:0] m_pw = '0;
  logic [63:0] m_pa = '0;
  bit          m_valid = 0;
  logic [63:0] m_data = '0;
  logic [6:0]  m_dest = '0;
  bit          m_ill = 0;
  string       m_tag = "R9";
  string       m_rtag = "R9";
  bit          acc_last = 0;
  bit          m_rdy;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // MSB-0 field extraction
  function automatic longint fld(logic [31:0] w, int lo, int hi);
    longint v = 0;
    for (int k = lo; k <= hi; k++) v = (v << 1) | longint'(w[31-k]);
    return v;
  endfunction

  task automatic emit(longint val, longint dst, string tag);
    m_valid = 1;
    m_data  = 64'(val);
    m_dest  = 7'(dst);
    m_rtag  = tag;
    m_tag   = tag;
  endtask

  task automatic step(logic [31:0] w, logic [63:0] a);
    longint op, ra, rt, si, imm, base, ra7, rt7;
    op = fld(w, 0, 5);
    rt = fld(w, 6, 10);
    ra = fld(w, 11, 15);
    si = fld(w, 16, 31);
    imm = (si >= 32768) ? si - 65536 : si;
    if (m_kind == 0) begin
      if (op == 14) begin
        base = (ra == 0) ? 0 : longint'(rfv(int'(ra)));
        emit(base + imm, rt, (ra == 0) ? "R2" : "R1");
      end else if (op == 1 && fld(w, 6, 7) == 2 && fld(w, 8, 8) == 0) begin
        m_kind = 1; m_pw = w; m_pa = a; m_tag = "R3";
      end else if (op == 9) begin
        m_kind = 2; m_pw = w; m_tag = "R6";
      end else begin
        m_tag = "R3";
      end
    end else begin
      if (op != 14) begin
        m_ill = 1; m_tag = "R7";
      end else if (m_kind == 1) begin
        imm = fld(m_pw, 14, 31) * 65536 + si;
        if (imm >= (longint'(1) << 33)) imm = imm - (longint'(1) << 34);
        if (fld(m_pw, 11, 11) == 1) begin
          base = longint'(m_pa);
          emit(base + imm, rt, "R5");
        end else begin
          base = (ra == 0) ? 0 : longint'(rfv(int'(ra)));
          emit(base + imm, rt, (ra == 0) ? "R2" : "R4");
        end
      end else begin
        ra7 = ra * 4 + fld(m_pw, 18, 19);
        rt7 = rt * 4 + fld(m_pw, 21, 22);
        base = (ra7 == 0) ? 0 : longint'(rfv(int'(ra7)));
        emit(base + imm, rt7, "R6");
      end
      m_kind = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_valid = 0; m_ill = 0; acc_last = 0; m_tag = "R9";
    end else begin
      m_rdy = !m_valid || res_ready;
      acc_last = in_valid && m_rdy;
      if (m_valid && res_ready) m_valid = 0;
      m_ill = 0;
      if (acc_last) step(in_word, in_addr);
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(in_ready === (!m_valid || res_ready), "R8", "in_ready",
          64'(in_ready), 64'(!m_valid || res_ready));
      chk(res_valid === m_valid, m_tag, "res_valid", 64'(res_valid), 64'(m_valid));
      if (m_valid && res_valid) begin
        chk(res_data === m_data, m_rtag, "res_data", res_data, m_data);
        chk(res_dest === m_dest, m_rtag, "res_dest", 64'(res_dest), 64'(m_dest));
      end
      chk(illegal === m_ill, "R7", "illegal", 64'(illegal), 64'(m_ill));
    end
  end

  always @(negedge clk) res_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;

  function automatic logic [31:0] plain_w(int rt, int ra, int si);
    return {6'd14, 5'(rt), 5'(ra), 16'(si)};
  endfunction

  function automatic logic [31:0] wide_w(bit r, int si0);
    return {6'd1, 2'b10, 1'b0, 2'b00, r, 2'b00, 18'(si0)};
  endfunction

  function automatic logic [31:0] vec_w(logic [9:0] ex);
    return {6'd9, 11'd0, ex, 5'd0};
  endfunction

  task automatic send(logic [31:0] w, logic [63:0] a);
    in_valid = 1; in_word = w; in_addr = a;
    do @(negedge clk); while (!acc_last);
    in_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(res_valid === 1'b0, "R9", "reset res_valid", 64'(res_valid), 0);
    chk(illegal === 1'b0, "R9", "reset illegal", 64'(illegal), 0);
    chk(in_ready === 1'b1, "R9", "reset in_ready", 64'(in_ready), 1);
    rst_n = 1;
    idle(2);
    // R1 / R2: single-word, 16-bit extremes
    send(plain_w(3, 5, 16'h0010), 64'h100);
    send(plain_w(4, 0, 16'h8000), 64'h104);
    send(plain_w(6, 7, 16'h7FFF), 64'h108);
    send(plain_w(6, 7, 16'h8000), 64'h10C);
    idle(2);
    // R4: 34-bit extremes, R2 with wide form
    send(wide_w(0, 18'h20000), 64'h200); send(plain_w(8, 4, 16'h0000), 64'h208);
    send(wide_w(0, 18'h1FFFF), 64'h210); send(plain_w(9, 0, 16'hFFFF), 64'h218);
    // R5: PC-relative with nonzero address
    send(wide_w(1, 18'h3FFFF), 64'h1000_0040); send(plain_w(2, 5, 16'hFFFC), 64'h1000_0048);
    send(wide_w(1, 18'h1FFFF), 64'hFFFF_0000_0000_1000); send(plain_w(1, 0, 16'hFFFF), 64'hFFFF_0000_0000_1008);
    idle(2);
    // R6: vector extension
    send(vec_w(10'b0110110000), 64'h300); send(plain_w(9, 3, 16'hFFFF), 64'h308);
    send(vec_w(10'b1000000000), 64'h310); send(plain_w(1, 0, 16'h0005), 64'h318);
    send(vec_w(10'b0010000000), 64'h320); send(plain_w(31, 0, 16'h0007), 64'h328);
    send(vec_w(10'b1111111111), 64'h330); send(plain_w(31, 31, 16'h8000), 64'h338);
    idle(2);
    // R7: bad suffixes
    send(wide_w(0, 18'h00001), 64'h400); send(32'h7C00_0000, 64'h408);
    idle(1);
    send(vec_w(10'b0110110000), 64'h410); send(wide_w(0, 18'h3), 64'h418);
    send(plain_w(5, 5, 16'h0001), 64'h420);
    idle(2);
    // R3: near-miss prefixes and other opcodes ignored
    send({6'd1, 2'b01, 24'h0}, 64'h500); send(plain_w(2, 2, 16'h0002), 64'h504);
    send({6'd1, 2'b10, 1'b1, 23'h0}, 64'h508); send(plain_w(2, 3, 16'h0003), 64'h50C);
    send(32'hFC00_1234, 64'h510);
    idle(2);
    // R9: reset while a prefix is held
    send(wide_w(1, 18'h00100), 64'h600);
    rst_n = 0;
    idle(2);
    chk(res_valid === 1'b0, "R9", "mid reset res_valid", 64'(res_valid), 0);
    chk(in_ready === 1'b1, "R9", "mid reset in_ready", 64'(in_ready), 1);
    rst_n = 1;
    idle(1);
    send(plain_w(7, 6, 16'h0040), 64'h608);
    idle(2);
    // R8: back-pressure
    rdy_rand = 1;
    for (int i = 0; i < 12; i++) send(plain_w(i, i + 1, i * 100), 64'(i * 4));
    // random mix under back-pressure
    for (int i = 0; i < 400; i++) begin
      int cat;
      logic [63:0] a;
      cat = int'($urandom % 5);
      a = {$urandom, $urandom} & ~64'h3;
      case (cat)
        0: send(plain_w(int'($urandom), int'($urandom), int'($urandom)), a);
        1: begin
          send(wide_w(bit'($urandom), int'($urandom)), a);
          send(plain_w(int'($urandom), int'($urandom), int'($urandom)), a + 8);
        end
        2: begin
          send(vec_w(10'($urandom)), a);
          send(plain_w(int'($urandom), int'($urandom), int'($urandom)), a + 8);
        end
        3: send({6'd31, 26'($urandom)}, a);
        default: begin
          send(wide_w(1'b0, int'($urandom)), a);
          send({6'd20, 26'($urandom)}, a + 8);
        end
      endcase
    end
    rdy_rand = 0;
    idle(6);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_run();
  end

endmodule